// File: doc/BRIEF.md
# Bidirectional Period Timer/Counter

This block is a counter of configurable width (16 bits by default) that moves one step on every clock cycle in which its count enable is high. A direction bit sets whether it counts up or down. The count runs between zero and a top value held in a period register. Counting up past the top value wraps the count to zero. Counting down past zero reloads the count with the period. Both cases raise a one-cycle event pulse.

A single write port sets the count value, the period or the direction. A write to the count wins over any stepping in the same cycle. The event output can drive the count enable of a second instance. The two instances together then form a counter of twice the width, with the first instance as the low half.

Top module: `bidir_timer`

## Requirements
- R1: After reset, `count_o` is 0, `dir_o` is 0 (up), `period_o` is all ones and `event_o` is 0.
- R2: With `cnt_en_i` high and no count write, counting up raises `count_o` by one at the next edge. With `cnt_en_i` low and no count write, `count_o` holds its value.
- R3: Counting up with `count_o` equal to `period_o`, an enabled edge sets `count_o` to 0. `event_o` is high for the following cycle.
- R4: Counting down, an enabled edge lowers `count_o` by one. When `count_o` is 0, an enabled edge instead loads `period_o` into the count and raises `event_o` for the following cycle.
- R5: A write with `wr_sel_i` = 2'b00 loads `wr_data_i` into the count at the next edge, whatever `cnt_en_i` is. In that cycle it overrides stepping, wrapping and reloading, and no event is raised. The code 2'b11 writes nothing.
- R6: A write with `wr_sel_i` = 2'b10 sets the direction from `wr_data_i[0]` (0 up, 1 down) at the next edge. Counting then continues from the current count in the new direction.
- R7: A write with `wr_sel_i` = 2'b01 replaces the period at the next edge. The new value is the top value from the next step onward.
- R8: Counting up with `count_o` above `period_o`, the counter keeps rising to all ones, then wraps to 0 and raises the event.
- R9: `event_o` is high only in the cycle after an enabled wrap or reload edge that had no count write.
- R10: When the event of one instance drives the count enable of a second instance, the second instance counts the wraps of the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Count enable; gates stepping |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 00 count, 01 period, 10 direction, 11 none |
| wr_data_i | input | WIDTH | Write data |
| count_o | output | WIDTH | Current count |
| period_o | output | WIDTH | Current top value |
| dir_o | output | 1 | Direction, 0 up, 1 down |
| event_o | output | 1 | One-cycle wrap/reload pulse |

## Verification
The assertions assume that the write strobe, the write target and the count enable are sampled only on clock edges. They also assume that any write target is legal in any cycle, including the cycle in which the count sits at its top value or at zero. The stimulus changes inputs only on falling edges. Random cycles pick every write target, including the unused code. Periods are drawn mostly small, so that wraps and reloads happen often, and sometimes drop below the current count. A directed phase covers a count write in the same cycle as a wrap, and a direction change made on the same edge as a step.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    SEL_COUNT  = 2'b00,
    SEL_PERIOD = 2'b01,
    SEL_DIR    = 2'b10,
    SEL_NONE   = 2'b11
  } tc_sel_e;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } tc_dir_e;
endpackage

// File: rtl/tc_cfg_regs.sv
module tc_cfg_regs
  import tc_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter logic [WIDTH-1:0] RST_PERIOD = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  tc_sel_e          wr_sel_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] period_o,
  output tc_dir_e          dir_o
);
  logic per_we, dir_we;

  assign per_we = wr_en_i && (wr_sel_i == SEL_PERIOD);
  assign dir_we = wr_en_i && (wr_sel_i == SEL_DIR);

  // unbuffered: new top applies from the next step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     period_o <= RST_PERIOD;
    else if (per_we) period_o <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dir_o <= DIR_UP;
    else if (dir_we) dir_o <= tc_dir_e'(wr_data_i[0]);
  end
endmodule

// File: rtl/tc_next_calc.sv
module tc_next_calc
  import tc_pkg::*;
#(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] count_i,
  input  logic [WIDTH-1:0] period_i,
  input  tc_dir_e          dir_i,
  output logic [WIDTH-1:0] next_o,
  output logic             wrap_o
);
  localparam logic [WIDTH-1:0] CNT_MAX = '1;

  logic at_top, at_max, at_bot;

  assign at_top = (count_i == period_i);
  assign at_max = (count_i == CNT_MAX);
  assign at_bot = (count_i == '0);

  always_comb begin
    if (dir_i == DIR_UP) begin
      // count above top runs on to max before wrapping
      wrap_o = at_top || at_max;
      next_o = wrap_o ? '0 : count_i + 1'b1;
    end else begin
      wrap_o = at_bot;
      next_o = wrap_o ? period_i : count_i - 1'b1;
    end
  end
endmodule

// File: rtl/bidir_timer.sv
module bidir_timer
  import tc_pkg::*;
#(
  parameter int unsigned WIDTH = 16,
  parameter logic [WIDTH-1:0] RST_PERIOD = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [WIDTH-1:0] wr_data_i,
  output logic [WIDTH-1:0] count_o,
  output logic [WIDTH-1:0] period_o,
  output logic             dir_o,
  output logic             event_o
);
  tc_sel_e          sel;
  tc_dir_e          dir;
  logic [WIDTH-1:0] cnt_q, cnt_nxt;
  logic             wrap, cnt_we, evt_q;

  assign sel    = tc_sel_e'(wr_sel_i);
  assign cnt_we = wr_en_i && (sel == SEL_COUNT);

  tc_cfg_regs #(.WIDTH(WIDTH), .RST_PERIOD(RST_PERIOD)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (sel),
    .wr_data_i (wr_data_i),
    .period_o  (period_o),
    .dir_o     (dir)
  );

  tc_next_calc #(.WIDTH(WIDTH)) u_calc (
    .count_i  (cnt_q),
    .period_i (period_o),
    .dir_i    (dir),
    .next_o   (cnt_nxt),
    .wrap_o   (wrap)
  );

  // software write beats step, wrap and reload
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (cnt_we)   cnt_q <= wr_data_i;
    else if (cnt_en_i) cnt_q <= cnt_nxt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) evt_q <= 1'b0;
    else         evt_q <= cnt_en_i && !cnt_we && wrap;
  end

  assign count_o = cnt_q;
  assign dir_o   = dir;
  assign event_o = evt_q;
endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
  parameter int unsigned WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cnt_en_i,
  input logic             wr_en_i,
  input logic [1:0]       wr_sel_i,
  input logic [WIDTH-1:0] wr_data_i,
  input logic [WIDTH-1:0] count_o,
  input logic [WIDTH-1:0] period_o,
  input logic             dir_o,
  input logic             event_o
);
  logic cw;
  assign cw = wr_en_i && (wr_sel_i == 2'b00);

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i && !cw) |=> $stable(count_o));

  a_r2_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !cw && !dir_o && count_o != period_o && count_o != '1)
    |=> count_o == $past(count_o) + 1'b1);

  a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !cw && !dir_o && count_o == period_o)
    |=> (count_o == '0) && event_o);

  a_r4_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en_i && !cw && dir_o && count_o == '0)
    |=> (count_o == $past(period_o)) && event_o);

  a_r5_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw |=> (count_o == $past(wr_data_i)) && !event_o);

  a_r7_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 2'b01) |=> period_o == $past(wr_data_i));

  a_r9_event_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(event_o) |-> $past(cnt_en_i) && !$past(cw));
endmodule

bind bidir_timer tc_checker #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnt_en_i  (cnt_en_i),
  .wr_en_i   (wr_en_i),
  .wr_sel_i  (wr_sel_i),
  .wr_data_i (wr_data_i),
  .count_o   (count_o),
  .period_o  (period_o),
  .dir_o     (dir_o),
  .event_o   (event_o)
);

// File: tb/tb_bidir_timer.sv
module tb_bidir_timer;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cnt_en_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = 2'b11;
  logic [15:0] wr_data_i = '0;
  logic [15:0] count_o, period_o, hi_count, hi_period;
  logic        dir_o, event_o, hi_dir, hi_event;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [15:0] m_cnt, m_per, m_hi;
  logic        m_dir, m_evt;

  always #5 clk_i = ~clk_i;

  bidir_timer dut (
    .clk_i, .rst_ni, .cnt_en_i, .wr_en_i, .wr_sel_i, .wr_data_i,
    .count_o, .period_o, .dir_o, .event_o
  );

  bidir_timer dut_hi (
    .clk_i(clk_i), .rst_ni(rst_ni), .cnt_en_i(event_o), .wr_en_i(1'b0),
    .wr_sel_i(2'b11), .wr_data_i(16'h0), .count_o(hi_count),
    .period_o(hi_period), .dir_o(hi_dir), .event_o(hi_event)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "count", count_o, m_cnt);
    chk(tag, "period", period_o, m_per);
    chk(tag, "dir", {15'd0, dir_o}, {15'd0, m_dir});
    chk(tag, "event", {15'd0, event_o}, {15'd0, m_evt});
    chk("R10", "hi_count", hi_count, m_hi);
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic en, input logic we, input logic [1:0] sel,
                      input logic [15:0] d, input string tag);
    logic [15:0] n_cnt, n_per;
    logic        n_dir, n_evt;
    cnt_en_i = en; wr_en_i = we; wr_sel_i = sel; wr_data_i = d;
    n_cnt = m_cnt; n_per = m_per; n_dir = m_dir; n_evt = 1'b0;
    if (we && sel == 2'b00) n_cnt = d;
    else if (en) begin
      if (!m_dir) begin
        if (m_cnt == m_per || m_cnt == 16'hFFFF) begin n_cnt = '0; n_evt = 1'b1; end
        else n_cnt = m_cnt + 16'd1;
      end else begin
        if (m_cnt == 16'd0) begin n_cnt = m_per; n_evt = 1'b1; end
        else n_cnt = m_cnt - 16'd1;
      end
    end
    if (we && sel == 2'b01) n_per = d;
    if (we && sel == 2'b10) n_dir = d[0];
    if (m_evt) m_hi = m_hi + 16'd1;
    m_cnt = n_cnt; m_per = n_per; m_dir = n_dir; m_evt = n_evt;
    @(posedge clk_i);
    @(negedge clk_i);
    compare(tag);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 200000) begin
        bad++; total++;
        $display("FAIL watchdog act=%0d exp=done", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    m_cnt = '0; m_per = 16'hFFFF; m_dir = 1'b0; m_evt = 1'b0; m_hi = '0;
    repeat (3) @(negedge clk_i);
    compare("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1");

    // R2 stepping and hold
    repeat (3) step(1, 0, 2'b11, 16'h0, "R2");
    repeat (2) step(0, 0, 2'b11, 16'h0, "R2");
    // R7 period write, then R3 wrap at top
    step(0, 1, 2'b01, 16'd5, "R7");
    repeat (3) step(1, 0, 2'b11, 16'h0, "R3");
    step(1, 0, 2'b11, 16'h0, "R9");
    // R4 down: reload at zero
    step(0, 1, 2'b00, 16'd0, "R5");
    step(0, 1, 2'b10, 16'd1, "R6");
    step(1, 0, 2'b11, 16'h0, "R4");
    step(1, 0, 2'b11, 16'h0, "R4");
    // R6 direction change on the same edge as a step
    step(1, 1, 2'b10, 16'd0, "R6");
    step(1, 0, 2'b11, 16'h0, "R6");
    // R5 count write at top during enabled wrap
    step(0, 1, 2'b00, 16'd5, "R5");
    step(1, 1, 2'b00, 16'd9, "R5");
    step(0, 1, 2'b11, 16'hABCD, "R5");
    // R8 top below count
    step(0, 1, 2'b01, 16'd3, "R8");
    step(1, 0, 2'b11, 16'h0, "R8");
    step(0, 1, 2'b00, 16'hFFFE, "R8");
    step(1, 0, 2'b11, 16'h0, "R8");
    step(1, 0, 2'b11, 16'h0, "R8");
    // R10 cascade with short low period
    step(0, 1, 2'b01, 16'd2, "R10");
    step(0, 1, 2'b00, 16'd0, "R10");
    repeat (30) step(1, 0, 2'b11, 16'h0, "R10");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] d;
      logic [1:0]  s;
      logic        we, en;
      en = ($urandom % 4) != 0;
      we = ($urandom % 5) == 0;
      s  = 2'($urandom % 4);
      d  = (($urandom % 4) == 0) ? 16'($urandom) : 16'($urandom % 16);
      step(en, we, s, d, "R2");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule